// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block generates the instruction address for a small 8-bit controller core. Each instruction slot normally moves the program counter forward by one. The block also handles the control-flow instructions: conditional skip, software interrupt, subroutine call, unconditional jump, subroutine return and return-from-interrupt. Return addresses are kept in a small circular hardware stack. The block also holds the global interrupt-enable flag.

The instruction decoder drives one request strobe per control-flow instruction, plus a jump target for call and jump. Any cycle in which `busy` is low counts as an instruction slot, and the request strobes are sampled in that cycle. Multi-cycle instructions raise `busy` for their extra cycles so that the fetch stage can stall. Request strobes that arrive while `busy` is high are discarded.

Top module: `pc_sequencer`

## Requirements
- R1: While `rstN` is low, `pc` is all ones (10'h3FF), `gie` is 0, `busy` is 0 and every stack slot holds zero with the stack pointer at slot 0.
- R2: In a slot with no request, `pc` advances by one at the next edge, wrapping from all ones to zero, and `busy` stays low.
- R3: A taken skip (`skipReq`) advances `pc` by one at the next edge and then inserts one bubble cycle with `busy` high. At the end of the bubble `pc` advances by one more, for a total of two over two cycles.
- R4: A software interrupt (`intReq`) pushes `pc`+1 and loads `pc` with 10'h002 at the next edge. `busy` is then high for two cycles, during which `pc` holds. The instruction takes three cycles in total, and `gie` is unchanged.
- R5: A return (`retReq`) pops the stack into `pc` at the next edge and is followed by one busy cycle with `pc` held. `gie` is unchanged.
- R6: A return-from-interrupt (`retfieReq`) behaves like R5 and also sets `gie` to 1.
- R7: A call (`callReq`) pushes `pc`+1, loads `pc` from `target`, and is followed by one busy cycle.
- R8: A jump (`gotoReq`) loads `pc` from `target`, is followed by one busy cycle, and leaves the stack untouched.
- R9: Request strobes present while `busy` is high have no effect on `pc`, `gie`, the stack or the busy duration.
- R10: When several requests are present in one slot, exactly one is taken, in this priority order from highest: interrupt, return-from-interrupt, return, call, jump, skip.
- R11: The stack holds 8 entries in LIFO order. A push onto a full stack overwrites the oldest entry and the pointer wraps.
- R12: A pop from an empty stack returns the slot just below the pointer, modulo 8, and moves the pointer down with wrap.
- R13: `gie` never goes from 1 to 0 except through reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| skipReq | input | 1 | Skip condition met for the current instruction |
| intReq | input | 1 | Software interrupt instruction |
| retReq | input | 1 | Subroutine return instruction |
| retfieReq | input | 1 | Return-from-interrupt instruction |
| callReq | input | 1 | Subroutine call to `target` |
| gotoReq | input | 1 | Jump to `target` |
| target | input | 10 | Destination address for call and jump |
| pc | output | 10 | Program counter |
| gie | output | 1 | Global interrupt enable |
| busy | output | 1 | High during the extra cycles of multi-cycle instructions |

## Verification
The hardest state to reach is a stack that has wrapped in both directions. The bench first issues ten back-to-back calls, so that the two oldest return addresses are overwritten. It then issues more returns than there were calls, which walks the pointer below empty and reads the wrapped slots. Requests are also held high through every busy cycle of interrupts, calls and skip bubbles, and all strobes are raised together, to show that requests made during a stall are discarded and that the priority order picks exactly one winner. The run ends with a long pseudo-random mix of requests and targets, compared cycle by cycle against a behavioural model.

// File: rtl/pc_sequencer_pkg.sv
`timescale 1ns/1ps
package pc_sequencer_pkg;
  typedef struct packed {
    logic incr;
    logic loadTarget;
    logic loadVector;
    logic popLoad;
    logic push;
    logic setGie;
  } seqStrobes_t;
endpackage

// File: rtl/pc_seq_stack.sv
`timescale 1ns/1ps
module pc_seq_stack #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] pushData,
  output logic [WIDTH-1:0] topData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] ptrBelow;

  // pointer names the next free slot; wraps in both directions
  assign ptrBelow = ptr - PTR_W'(1);
  assign topData  = slots[ptrBelow];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else if (push) begin
      slots[ptr] <= pushData;
      ptr <= ptr + PTR_W'(1);
    end else if (pop) begin
      ptr <= ptrBelow;
    end
  end
endmodule

// File: rtl/pc_seq_ctrl.sv
`timescale 1ns/1ps
module pc_seq_ctrl
  import pc_sequencer_pkg::*;
#(
  parameter int INT_CYCLES  = 3,
  parameter int XFER_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        skipReq,
  input  logic        intReq,
  input  logic        retReq,
  input  logic        retfieReq,
  input  logic        callReq,
  input  logic        gotoReq,
  output seqStrobes_t strobes,
  output logic        busy
);
  localparam int SKIP_CYCLES = 2;
  localparam int MAX_CYC = (INT_CYCLES > XFER_CYCLES) ? INT_CYCLES : XFER_CYCLES;
  localparam int CNT_W = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;

  logic [CNT_W-1:0] busyCnt, busyCntNext;
  logic skipPend, skipPendNext;

  assign busy = (busyCnt != '0);

  always_comb begin
    strobes      = '0;
    busyCntNext  = busyCnt;
    skipPendNext = skipPend;
    if (busy) begin
      busyCntNext = busyCnt - CNT_W'(1);
      if (busyCnt == CNT_W'(1)) begin
        strobes.incr = skipPend;
        skipPendNext = 1'b0;
      end
    end else if (intReq) begin
      strobes.loadVector = 1'b1;
      strobes.push       = 1'b1;
      busyCntNext        = CNT_W'(INT_CYCLES - 1);
    end else if (retfieReq) begin
      strobes.popLoad = 1'b1;
      strobes.setGie  = 1'b1;
      busyCntNext     = CNT_W'(XFER_CYCLES - 1);
    end else if (retReq) begin
      strobes.popLoad = 1'b1;
      busyCntNext     = CNT_W'(XFER_CYCLES - 1);
    end else if (callReq) begin
      strobes.push       = 1'b1;
      strobes.loadTarget = 1'b1;
      busyCntNext        = CNT_W'(XFER_CYCLES - 1);
    end else if (gotoReq) begin
      strobes.loadTarget = 1'b1;
      busyCntNext        = CNT_W'(XFER_CYCLES - 1);
    end else if (skipReq) begin
      strobes.incr = 1'b1;
      skipPendNext = 1'b1;
      busyCntNext  = CNT_W'(SKIP_CYCLES - 1);
    end else begin
      strobes.incr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt  <= '0;
      skipPend <= 1'b0;
    end else begin
      busyCnt  <= busyCntNext;
      skipPend <= skipPendNext;
    end
  end
endmodule

// File: rtl/pc_seq_datapath.sv
`timescale 1ns/1ps
module pc_seq_datapath
  import pc_sequencer_pkg::*;
#(
  parameter int PC_WIDTH    = 10,
  parameter int STACK_DEPTH = 8,
  parameter int INT_VECTOR  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobes_t         strobes,
  input  logic [PC_WIDTH-1:0] target,
  output logic [PC_WIDTH-1:0] pc,
  output logic                gie
);
  logic [PC_WIDTH-1:0] pcPlusOne;
  logic [PC_WIDTH-1:0] stackTop;

  assign pcPlusOne = pc + PC_WIDTH'(1);

  pc_seq_stack #(.WIDTH(PC_WIDTH), .DEPTH(STACK_DEPTH)) retStack (
    .clk(clk),
    .rstN(rstN),
    .push(strobes.push),
    .pop(strobes.popLoad),
    .pushData(pcPlusOne),
    .topData(stackTop)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc  <= '1;
      gie <= 1'b0;
    end else begin
      if (strobes.popLoad)         pc <= stackTop;
      else if (strobes.loadVector) pc <= PC_WIDTH'(INT_VECTOR);
      else if (strobes.loadTarget) pc <= target;
      else if (strobes.incr)       pc <= pcPlusOne;
      if (strobes.setGie) gie <= 1'b1;
    end
  end
endmodule

// File: rtl/pc_sequencer.sv
`timescale 1ns/1ps
module pc_sequencer
  import pc_sequencer_pkg::*;
#(
  parameter int PC_WIDTH    = 10,
  parameter int STACK_DEPTH = 8,
  parameter int INT_VECTOR  = 2,
  parameter int INT_CYCLES  = 3,
  parameter int XFER_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                skipReq,
  input  logic                intReq,
  input  logic                retReq,
  input  logic                retfieReq,
  input  logic                callReq,
  input  logic                gotoReq,
  input  logic [PC_WIDTH-1:0] target,
  output logic [PC_WIDTH-1:0] pc,
  output logic                gie,
  output logic                busy
);
  seqStrobes_t strobes;

  pc_seq_ctrl #(.INT_CYCLES(INT_CYCLES), .XFER_CYCLES(XFER_CYCLES)) ctrl (
    .clk(clk), .rstN(rstN),
    .skipReq(skipReq), .intReq(intReq), .retReq(retReq),
    .retfieReq(retfieReq), .callReq(callReq), .gotoReq(gotoReq),
    .strobes(strobes), .busy(busy)
  );

  pc_seq_datapath #(.PC_WIDTH(PC_WIDTH), .STACK_DEPTH(STACK_DEPTH),
                    .INT_VECTOR(INT_VECTOR)) datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .target(target),
    .pc(pc), .gie(gie)
  );
endmodule

// File: rtl/pc_sequencer_checker.sv
`timescale 1ns/1ps
module pc_sequencer_checker #(
  parameter int PC_WIDTH   = 10,
  parameter int INT_VECTOR = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                skipReq,
  input logic                intReq,
  input logic                retReq,
  input logic                retfieReq,
  input logic                callReq,
  input logic                gotoReq,
  input logic [PC_WIDTH-1:0] target,
  input logic [PC_WIDTH-1:0] pc,
  input logic                gie,
  input logic                busy
);
  logic anyReq;
  assign anyReq = skipReq | intReq | retReq | retfieReq | callReq | gotoReq;

  assert_plain_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !anyReq) |=> (!busy && pc == PC_WIDTH'($past(pc) + PC_WIDTH'(1))));

  assert_skip_bubble_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && skipReq && !intReq && !retfieReq && !retReq && !callReq && !gotoReq)
    |=> busy ##1 (!busy && pc == PC_WIDTH'($past(pc, 2) + PC_WIDTH'(2))));

  assert_int_vector_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && intReq) |=> (busy && pc == PC_WIDTH'(INT_VECTOR)));

  assert_int_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && intReq) |=> ##1 (busy && $stable(pc) && $stable(gie)));

  assert_retfie_gie_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !intReq && retfieReq) |=> (gie && busy));

  assert_goto_target_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && gotoReq && !intReq && !retfieReq && !retReq && !callReq)
    |=> (busy && pc == $past(target)));

  assert_gie_sticky_R13: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(gie));
endmodule

bind pc_sequencer pc_sequencer_checker #(.PC_WIDTH(PC_WIDTH), .INT_VECTOR(INT_VECTOR)) chk (
  .clk(clk), .rstN(rstN), .skipReq(skipReq), .intReq(intReq), .retReq(retReq),
  .retfieReq(retfieReq), .callReq(callReq), .gotoReq(gotoReq), .target(target),
  .pc(pc), .gie(gie), .busy(busy)
);

// File: tb/pc_sequencer_test.sv
`timescale 1ns/1ps
module pc_sequencer_test;
  localparam int MASK = 'h3FF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] req = '0;   // {int, retfie, ret, call, goto, skip}
  logic [9:0] target = '0;
  logic [9:0] pc;
  logic gie, busy;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit modelOn = 0;
  string prevTag = "R2";

  int mPc, mGie, mLeft, mSkip, mSp;
  int mStack[8];

  always #2 clk = ~clk;

  pc_sequencer uut (
    .clk(clk), .rstN(rstN),
    .skipReq(req[0]), .gotoReq(req[1]), .callReq(req[2]),
    .retReq(req[3]), .retfieReq(req[4]), .intReq(req[5]),
    .target(target), .pc(pc), .gie(gie), .busy(busy)
  );

  task automatic modelPush(input int v);
    mStack[mSp] = v & MASK;
    mSp = (mSp + 1) % 8;
  endtask

  task automatic modelPop();
    mSp = (mSp + 7) % 8;
    mPc = mStack[mSp];
  endtask

  always @(posedge clk) begin
    if (modelOn) begin
      if (mLeft > 0) begin
        if (mLeft == 1 && mSkip == 1) begin
          mPc = (mPc + 1) & MASK;
          mSkip = 0;
        end
        mLeft--;
      end else if (req[5]) begin
        modelPush(mPc + 1); mPc = 2; mLeft = 2;
      end else if (req[4]) begin
        modelPop(); mGie = 1; mLeft = 1;
      end else if (req[3]) begin
        modelPop(); mLeft = 1;
      end else if (req[2]) begin
        modelPush(mPc + 1); mPc = int'(target); mLeft = 1;
      end else if (req[1]) begin
        mPc = int'(target); mLeft = 1;
      end else if (req[0]) begin
        mPc = (mPc + 1) & MASK; mSkip = 1; mLeft = 1;
      end else begin
        mPc = (mPc + 1) & MASK;
      end
    end
  end

  task automatic compare(input string tag);
    checks++;
    if (int'(pc) != mPc || int'(gie) != mGie || busy != (mLeft != 0)) begin
      failures++;
      $display("FAIL %s: pc=%h gie=%0d busy=%0d expected pc=%h gie=%0d busy=%0d",
               tag, pc, gie, busy, mPc[9:0], mGie, (mLeft != 0));
    end
  endtask

  task automatic cyc(input logic [5:0] r, input int tgt, input string tag);
    @(negedge clk);
    compare(prevTag);
    req = r;
    target = tgt[9:0];
    prevTag = tag;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(6'b0, 0, tag);
  endtask

  initial begin
    mPc = MASK; mGie = 0; mLeft = 0; mSkip = 0; mSp = 0;
    for (int i = 0; i < 8; i++) mStack[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    checks++;
    if (pc !== 10'h3FF || gie !== 1'b0 || busy !== 1'b0) begin
      failures++;
      $display("FAIL R1: pc=%h gie=%b busy=%b expected pc=3ff gie=0 busy=0", pc, gie, busy);
    end
    rstN = 1'b1;
    modelOn = 1;
    // R2: plain stepping, first step wraps all ones to zero
    idle(6, "R2");
    // R3: skip taken
    cyc(6'b000001, 0, "R3"); idle(3, "R3");
    cyc(6'b000001, 0, "R3"); cyc(6'b000001, 0, "R3"); idle(2, "R3");
    // R7 / R5: nested calls and returns
    cyc(6'b000100, 'h100, "R7"); idle(2, "R7");
    cyc(6'b000100, 'h200, "R7"); idle(2, "R7");
    cyc(6'b001000, 0, "R5"); idle(2, "R5");
    cyc(6'b001000, 0, "R5"); idle(2, "R5");
    // R4 / R6: software interrupt then return with enable
    cyc(6'b100000, 0, "R4"); idle(4, "R4");
    cyc(6'b010000, 0, "R6"); idle(3, "R6");
    // R8: jump
    cyc(6'b000010, 'h055, "R8"); idle(3, "R8");
    // R9: strobes held during busy cycles are ignored
    cyc(6'b000100, 'h300, "R9"); cyc(6'b111111, 'h111, "R9"); idle(2, "R9");
    cyc(6'b100000, 0, "R9"); cyc(6'b111111, 'h222, "R9"); cyc(6'b111111, 'h222, "R9"); idle(2, "R9");
    cyc(6'b000001, 0, "R9"); cyc(6'b111111, 'h333, "R9"); idle(2, "R9");
    // R10: simultaneous requests, priority
    cyc(6'b111111, 'h0AA, "R10"); idle(3, "R10");
    cyc(6'b011111, 'h0AB, "R10"); idle(2, "R10");
    cyc(6'b001111, 'h0AC, "R10"); idle(2, "R10");
    cyc(6'b000111, 'h0AD, "R10"); idle(2, "R10");
    cyc(6'b000011, 'h0AE, "R10"); idle(2, "R10");
    // R11: overflow by ten calls then unwind
    for (int k = 0; k < 10; k++) begin
      cyc(6'b000100, 'h040 + k * 8, "R11"); idle(1, "R11");
    end
    for (int k = 0; k < 8; k++) begin
      cyc(6'b001000, 0, "R11"); idle(1, "R11");
    end
    // R12: underflow reads wrapped slots
    for (int k = 0; k < 5; k++) begin
      cyc(6'b001000, 0, "R12"); idle(1, "R12");
    end
    // R13: pseudo-random mix
    for (int k = 0; k < 400; k++) begin
      int sel;
      logic [5:0] r;
      sel = int'($urandom_range(0, 15));
      r = (sel < 6) ? (6'b1 << sel) : ((sel == 6) ? 6'($urandom_range(0, 63)) : 6'b0);
      cyc(r, int'($urandom_range(0, 1023)), "R13");
    end
    idle(3, "R13");
    @(negedge clk);
    compare(prevTag);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule